// File: doc/BRIEF.md
# Clocked Synchronous Serial Port

This block moves 8-bit characters over a three-wire clocked serial link: one data output, one data input and a serial clock pin that can be driven or received. The serial clock comes from one of two places. An internal divider makes it and the block drives the pin, or an outside device drives the pin and the block follows its edges after synchronizing them. Bits go out least significant first. Transmit data changes on the falling serial clock edge, and receive data is sampled on the rising edge.

Software works through a small set of register-style signals. It loads a transmit holding register and reads a receive holding register. It sees three flags: transmit-empty, receive-full and overrun. The transmit and receive enables are separate. With the internal clock and only the receiver enabled, the port keeps clocking characters in, one after another, until the receiver is disabled or an overrun stops it. Turning the transmitter off resets its path. Turning the receiver off leaves the received data and the receive flags exactly as they were.

Top module: `sync_serial_port`

## Requirements
- R1: Every character takes exactly eight serial clock pulses and is sent and received least significant bit first. The transmit line changes on the falling edge and the receive line is sampled on the rising edge.
- R2: With the internal clock selected, `sck_o` stays high whenever no character is in progress.
- R3: When `cfg_ext_clk`=0 the internal divider is the clock source and `sck_oe`=1. When `cfg_ext_clk`=1, `sck_oe`=0 and the port shifts on the edges of `sck_i`, which first pass through a two-stage synchronizer.
- R4: The internal serial clock period is 2*(N+1) system clocks, where N is `cfg_div`.
- R5: A write to the transmit holding register clears `tx_empty`. When the next character starts, the data moves into the shift register and `tx_empty` returns to 1. A write made while `tx_en`=0 is ignored and `tx_empty` stays 1.
- R6: With the internal clock, `rx_en`=1 and `tx_en`=0, the port clocks characters in back to back. This stops only when `rx_en` is cleared or when an overrun occurs.
- R7: Clearing `tx_en` forces `tx_empty` to 1 and `sd_o` to 1, and reinitializes the transmit shift register.
- R8: Clearing `rx_en` leaves `rx_full`, `overrun` and `rdr_data` unchanged.
- R9: If a character completes while `rx_full`=1, then `overrun` is set, the new character is discarded and `rdr_data` keeps the old value. `rd_ack` clears `rx_full` and `ovr_clr` clears `overrun`.
- R10: A `cfg_wr` is ignored while either `tx_en` or `rx_en` is 1.
- R11: With the internal clock and `tx_en`=1, the clock runs only while transmit data is pending. With both enables set and no data written, no clock pulses appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Format write strobe (ignored while enabled) |
| cfg_ext_clk | input | 1 | Clock source: 0 internal divider, 1 external pin |
| cfg_div | input | DIV_W | Divider value N |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| tdr_wr | input | 1 | Transmit holding register write strobe |
| tdr_wdata | input | DATA_W | Transmit data |
| rd_ack | input | 1 | Clears the receive-full flag |
| ovr_clr | input | 1 | Clears the overrun flag |
| rdr_data | output | DATA_W | Receive holding register |
| rx_full | output | 1 | Receive-full flag |
| tx_empty | output | 1 | Transmit-empty flag |
| overrun | output | 1 | Overrun flag |
| sck_i | input | 1 | Serial clock pin, input side |
| sck_o | output | 1 | Serial clock pin, output side |
| sck_oe | output | 1 | Serial clock pin drive enable |
| sd_i | input | 1 | Serial data in |
| sd_o | output | 1 | Serial data out |

## Verification
A bit counter that is out of step shows up on the very next character, either as a fall count other than eight on `sck_o` or as a byte that loops back rotated. A wrong divider state shows up as soon as the gap between two clock falls differs from 2*(N+1). The flag logic is checked inside one character time. A lost or false overrun changes `rdr_data` or `overrun` as soon as the second character ends, and a receiver that fails to stop keeps `sck_o` toggling in a window where it must stay high.

// File: rtl/sio_pkg.sv
// Shared types for the clocked serial port.
// Assumes: nothing beyond IEEE 1800-2017.
package sio_pkg;
    typedef enum logic {
        SRC_INTERNAL = 1'b0,
        SRC_EXTERNAL = 1'b1
    } clk_src_e;
endpackage

// File: rtl/sio_clkgen.sv
// Serial clock source: an internal half-period divider, or the edges of an
// external pin after a two-stage synchronizer. Emits one-cycle fall and rise
// events in the system clock domain.
// Assumes: div changes only while run_en is low.
module sio_clkgen
    import sio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  clk_src_e         src,
    input  logic [DIV_W-1:0] div,
    input  logic             run_en,
    input  logic             want,
    input  logic             sck_i,
    output logic             sck_o,
    output logic             fall_ev,
    output logic             rise_ev
);
    logic [DIV_W-1:0] cnt_q;
    logic             sck_q;
    logic [2:0]       sync_q;
    logic             running;
    logic             tick;

    assign running = want || !sck_q;
    assign tick    = (cnt_q == div);

    // Internal divider: toggles the clock every div+1 cycles while running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en || src == SRC_EXTERNAL) begin
            cnt_q <= '0;
            sck_q <= 1'b1;
        end else if (!running) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
            sck_q <= !sck_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Two synchronizer stages plus a history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 3'b111;
        else        sync_q <= {sync_q[1:0], sck_i};
    end

    // Event selection between the two sources.
    always_comb begin
        if (src == SRC_EXTERNAL) begin
            fall_ev = run_en && sync_q[2] && !sync_q[1];
            rise_ev = run_en && !sync_q[2] && sync_q[1];
        end else begin
            fall_ev = run_en && running && tick && sck_q;
            rise_ev = run_en && tick && !sck_q;
        end
    end

    assign sck_o = sck_q;

    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= div); // R4
endmodule

// File: rtl/sio_tx.sv
// Transmit path: holding register, shift register and empty flag.
// Assumes: load and shift are never high in the same cycle.
module sio_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              load,
    input  logic              shift,
    output logic              tx_empty,
    output logic              sd_o
);
    logic [DATA_W-1:0] tdr_q;
    logic [DATA_W-1:0] tsr_q;

    // Holding register, empty flag and LSB-first shifter.
    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en) begin
            tdr_q    <= '0;
            tsr_q    <= '1;
            tx_empty <= 1'b1;
            sd_o     <= 1'b1;
        end else begin
            if (wr) tdr_q <= wdata;
            if (wr) tx_empty <= 1'b0;
            else if (load && !tx_empty) tx_empty <= 1'b1;
            if (load) begin
                if (!tx_empty) begin
                    tsr_q <= {1'b1, tdr_q[DATA_W-1:1]};
                    sd_o  <= tdr_q[0];
                end else begin
                    tsr_q <= '1;
                    sd_o  <= 1'b1;
                end
            end else if (shift) begin
                tsr_q <= {1'b1, tsr_q[DATA_W-1:1]};
                sd_o  <= tsr_q[0];
            end
        end
    end

    AST_TXE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (tx_empty && sd_o)); // R7
endmodule

// File: rtl/sio_rx.sv
// Receive path: shift register, holding register, full and overrun flags.
// Assumes: done coincides with the sample of the last bit.
module sio_rx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              sample,
    input  logic              done,
    input  logic              sd_i,
    input  logic              rd_ack,
    input  logic              ovr_clr,
    output logic [DATA_W-1:0] rdr_data,
    output logic              rx_full,
    output logic              overrun
);
    logic [DATA_W-1:0] rsr_q;
    logic [DATA_W-1:0] next_word;
    logic              blocked;

    assign next_word = {sd_i, rsr_q[DATA_W-1:1]};
    assign blocked   = rx_full && !rd_ack;

    // Shift register: LSB arrives first and ends at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                rsr_q <= '0;
        else if (sample && rx_en)  rsr_q <= next_word;
    end

    // Flags and holding register; the enable never clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdr_data <= '0;
            rx_full  <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            if (done && rx_en && !blocked) begin
                rdr_data <= next_word;
                rx_full  <= 1'b1;
            end else if (rd_ack) begin
                rx_full  <= 1'b0;
            end
            if (done && rx_en && blocked) overrun <= 1'b1;
            else if (ovr_clr)             overrun <= 1'b0;
        end
    end

    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> $stable(rdr_data)); // R8
    AST_OVR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rx_en && rx_full && !rd_ack) |=> (overrun && $stable(rdr_data))); // R9
endmodule

// File: rtl/sync_serial_port.sv
// Top level: format register, character sequencer and the two data paths.
// Assumes: software disables both enables before a format change.
module sync_serial_port
    import sio_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int DIV_W     = 8,
    parameter int DIV_RESET = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_ext_clk,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              tdr_wr,
    input  logic [DATA_W-1:0] tdr_wdata,
    input  logic              rd_ack,
    input  logic              ovr_clr,
    output logic [DATA_W-1:0] rdr_data,
    output logic              rx_full,
    output logic              tx_empty,
    output logic              overrun,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              sd_i,
    output logic              sd_o
);
    localparam int                CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(DATA_W - 1);

    clk_src_e         src_q;
    logic [DIV_W-1:0] div_q;
    logic             run_en;
    logic             active_q;
    logic [CNT_W-1:0] bit_cnt;
    logic             start_ok;
    logic             fall_ev, rise_ev;
    logic             start, shift, sample, done;

    assign run_en = tx_en || rx_en;

    // Format register, writable only while both directions are disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= SRC_INTERNAL;
            div_q <= DIV_W'(DIV_RESET);
        end else if (cfg_wr && !run_en) begin
            src_q <= cfg_ext_clk ? SRC_EXTERNAL : SRC_INTERNAL;
            div_q <= cfg_div;
        end
    end

    // Whether a new character may begin at the next falling edge.
    always_comb begin
        if (src_q == SRC_EXTERNAL)
            start_ok = rx_en || (tx_en && !tx_empty);
        else
            start_ok = (tx_en && !tx_empty) || (rx_en && !tx_en && !overrun);
    end

    assign start  = fall_ev && !active_q && start_ok;
    assign shift  = fall_ev && active_q;
    assign sample = rise_ev && active_q;
    assign done   = sample && (bit_cnt == LAST);

    // Character sequencer: counts rising edges within one character.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) begin
            active_q <= 1'b0;
            bit_cnt  <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            bit_cnt  <= '0;
        end else if (sample) begin
            if (bit_cnt == LAST) active_q <= 1'b0;
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    sio_clkgen #(.DIV_W(DIV_W)) i_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (src_q),
        .div     (div_q),
        .run_en  (run_en),
        .want    (active_q || start_ok),
        .sck_i   (sck_i),
        .sck_o   (sck_o),
        .fall_ev (fall_ev),
        .rise_ev (rise_ev)
    );

    sio_tx #(.DATA_W(DATA_W)) i_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_en    (tx_en),
        .wr       (tdr_wr),
        .wdata    (tdr_wdata),
        .load     (start),
        .shift    (shift),
        .tx_empty (tx_empty),
        .sd_o     (sd_o)
    );

    sio_rx #(.DATA_W(DATA_W)) i_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_en    (rx_en),
        .sample   (sample),
        .done     (done),
        .sd_i     (sd_i),
        .rd_ack   (rd_ack),
        .ovr_clr  (ovr_clr),
        .rdr_data (rdr_data),
        .rx_full  (rx_full),
        .overrun  (overrun)
    );

    assign sck_oe = (src_q == SRC_INTERNAL);

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q == SRC_INTERNAL && !active_q) |-> sck_o); // R2
    AST_EIGHT_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(active_q) && $past(run_en)) |-> ($past(bit_cnt) == LAST)); // R1
    AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        run_en |=> ($stable(src_q) && $stable(div_q))); // R10
endmodule

// File: tb/test_sync_serial_port.sv
module test_sync_serial_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0, cfg_ext_clk = 1'b0;
    logic [7:0] cfg_div = 8'd0;
    logic       tx_en = 1'b0, rx_en = 1'b0;
    logic       tdr_wr = 1'b0;
    logic [7:0] tdr_wdata = 8'd0;
    logic       rd_ack = 1'b0, ovr_clr = 1'b0;
    logic [7:0] rdr_data;
    logic       rx_full, tx_empty, overrun;
    logic       sck_i = 1'b1;
    logic       sck_o, sck_oe, sd_o;
    logic       sd_sel = 1'b0, bench_sd = 1'b1;
    logic       sd_i;

    int tests = 0, fails = 0, cyc = 0;
    int fall_cnt = 0, gap_err = 0, last_fall = 0, exp_gap = 2;
    bit last_valid = 0, mon_clear = 0;
    logic prev_sck = 1'b1;

    assign sd_i = sd_sel ? bench_sd : sd_o;

    always #4 clk = !clk;

    sync_serial_port i_sync_serial_port (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_ext_clk(cfg_ext_clk),
        .cfg_div(cfg_div), .tx_en(tx_en), .rx_en(rx_en), .tdr_wr(tdr_wr),
        .tdr_wdata(tdr_wdata), .rd_ack(rd_ack), .ovr_clr(ovr_clr),
        .rdr_data(rdr_data), .rx_full(rx_full), .tx_empty(tx_empty),
        .overrun(overrun), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
        .sd_i(sd_i), .sd_o(sd_o)
    );

    // Monitor of sck_o falls and the gap between them (pre-edge values).
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mon_clear) begin
            fall_cnt <= 0; gap_err <= 0; last_valid <= 0;
        end else if (prev_sck && !sck_o) begin
            fall_cnt <= fall_cnt + 1;
            if (last_valid && (cyc - last_fall) != exp_gap) gap_err <= gap_err + 1;
            last_fall  <= cyc;
            last_valid <= 1;
        end
        prev_sck <= sck_o;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_mon();
        @(negedge clk); mon_clear = 1;
        @(negedge clk); mon_clear = 0;
    endtask

    task automatic set_cfg(input logic ext, input logic [7:0] n);
        @(negedge clk); tx_en = 0; rx_en = 0;
        @(negedge clk); cfg_wr = 1; cfg_ext_clk = ext; cfg_div = n;
        @(negedge clk); cfg_wr = 0;
        exp_gap = 2 * (n + 1);
    endtask

    task automatic write_tdr(input logic [7:0] v);
        @(negedge clk); tdr_wr = 1; tdr_wdata = v;
        @(negedge clk); tdr_wr = 0;
    endtask

    task automatic pulse_ack();
        @(negedge clk); rd_ack = 1; ovr_clr = 1;
        @(negedge clk); rd_ack = 0; ovr_clr = 0;
    endtask

    task automatic wait_full(input int lim);
        for (int i = 0; i < lim && !rx_full; i++) @(negedge clk);
    endtask

    // Drive eight external clock pulses, bench data LSB first on each fall.
    task automatic ext_char(input logic [7:0] v);
        for (int b = 0; b < 8; b++) begin
            @(negedge clk); sck_i = 0; bench_sd = v[b];
            cycles(8);
            sck_i = 1;
            cycles(8);
        end
        cycles(6);
    endtask

    // Watchdog.
    initial begin
        wait (cyc > 150000);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        cycles(3);
        rst_n = 1;
        cycles(2);
        // Reset state
        chk(tx_empty == 1, "R5 reset tx_empty", tx_empty, 1);
        chk(rx_full == 0 && overrun == 0, "R9 reset flags", {rx_full, overrun}, 0);
        chk(sck_o == 1, "R2 reset sck idle", sck_o, 1);
        chk(sck_oe == 1, "R3 reset internal source", sck_oe, 1);

        // R1/R4/R5: duplex loopback sweep over all byte values and four dividers
        for (int n = 0; n < 4; n++) begin
            set_cfg(0, 8'(n));
            @(negedge clk); tx_en = 1; rx_en = 1;
            for (int k = 0; k < 64; k++) begin
                logic [7:0] v;
                v = 8'(n * 64 + k);
                clear_mon();
                @(negedge clk); tdr_wr = 1; tdr_wdata = v;
                @(negedge clk); tdr_wr = 0;
                chk(tx_empty == 0, "R5 write clears empty", tx_empty, 0);
                wait_full(200);
                cycles(2);
                chk(rdr_data == v, "R1 loopback byte", rdr_data, v);
                chk(fall_cnt == 8, "R1 eight pulses", fall_cnt, 8);
                chk(gap_err == 0, "R4 clock period", gap_err, 0);
                chk(tx_empty == 1, "R5 empty after load", tx_empty, 1);
                chk(sck_o == 1, "R2 idle high after char", sck_o, 1);
                pulse_ack();
            end
        end

        // R11: enabled but nothing to send -> no clock
        set_cfg(0, 8'd1);
        @(negedge clk); tx_en = 1; rx_en = 1;
        clear_mon();
        cycles(60);
        chk(fall_cnt == 0, "R11 no clock without data", fall_cnt, 0);

        // R9: overrun in duplex
        write_tdr(8'h5A);
        wait_full(200);
        write_tdr(8'hC3);
        for (int i = 0; i < 200 && !overrun; i++) @(negedge clk);
        cycles(2);
        chk(overrun == 1, "R9 overrun set", overrun, 1);
        chk(rdr_data == 8'h5A, "R9 old data kept", rdr_data, 8'h5A);
        chk(rx_full == 1, "R9 full kept", rx_full, 1);
        pulse_ack();
        chk(rx_full == 0 && overrun == 0, "R9 flags cleared", {rx_full, overrun}, 0);

        // R10: format write ignored while enabled
        @(negedge clk); cfg_wr = 1; cfg_ext_clk = 1;
        @(negedge clk); cfg_wr = 0;
        cycles(1);
        chk(sck_oe == 1, "R10 cfg locked", sck_oe, 1);

        // R7 and R5: transmitter disable mid-character, writes ignored when off
        set_cfg(0, 8'd20);
        @(negedge clk); tx_en = 1; rx_en = 0;
        write_tdr(8'h00);
        for (int i = 0; i < 100 && sck_o; i++) @(negedge clk);
        chk(sd_o == 0, "R1 first bit out", sd_o, 0);
        @(negedge clk); tx_en = 0;
        cycles(1);
        chk(tx_empty == 1 && sd_o == 1, "R7 tx reset on disable", {tx_empty, sd_o}, 3);
        chk(sck_o == 1, "R2 clock stops when disabled", sck_o, 1);
        write_tdr(8'h33);
        cycles(1);
        chk(tx_empty == 1, "R5 write ignored while off", tx_empty, 1);

        // R6/R8: receive-only runs until overrun, flags survive disable
        set_cfg(0, 8'd1);
        pulse_ack();
        sd_sel = 1; bench_sd = 0;
        clear_mon();
        @(negedge clk); rx_en = 1;
        for (int i = 0; i < 300 && !overrun; i++) @(negedge clk);
        cycles(40);
        chk(overrun == 1, "R6 overrun stops rx", overrun, 1);
        chk(fall_cnt == 16, "R6 two chars then stop", fall_cnt, 16);
        chk(sck_o == 1, "R6 clock idle after overrun", sck_o, 1);
        chk(rdr_data == 8'h00, "R6 received zeros", rdr_data, 0);
        @(negedge clk); rx_en = 0;
        cycles(3);
        chk(rx_full == 1 && overrun == 1, "R8 flags kept", {rx_full, overrun}, 3);
        chk(rdr_data == 8'h00, "R8 data kept", rdr_data, 0);

        // R6: continuous receive with acks, stops on disable
        pulse_ack();
        bench_sd = 1;
        clear_mon();
        @(negedge clk); rx_en = 1;
        for (int i = 0; i < 400 && fall_cnt < 40; i++) begin
            @(negedge clk);
            if (rx_full) begin rd_ack = 1; @(negedge clk); rd_ack = 0; end
        end
        chk(fall_cnt >= 40, "R6 continuous clocking", fall_cnt, 40);
        chk(overrun == 0, "R6 no overrun when acked", overrun, 0);
        @(negedge clk); rx_en = 0;
        clear_mon();
        cycles(40);
        chk(fall_cnt == 0 && sck_o == 1, "R6 stops on rx disable", fall_cnt, 0);

        // R3: external clock, receive-only from bench data
        pulse_ack();
        set_cfg(1, 8'd0);
        cycles(1);
        chk(sck_oe == 0, "R3 external source", sck_oe, 0);
        @(negedge clk); rx_en = 1;
        ext_char(8'h96);
        chk(rx_full == 1 && rdr_data == 8'h96, "R3 external rx", rdr_data, 8'h96);
        pulse_ack();

        // R3/R1: external clock duplex loopback
        sd_sel = 0;
        @(negedge clk); tx_en = 1;
        for (int j = 0; j < 6; j++) begin
            logic [7:0] v;
            v = 8'(8'h37 * j + 8'h81);
            write_tdr(v);
            ext_char(8'h00);
            chk(rdr_data == v, "R3 external loopback", rdr_data, v);
            chk(tx_empty == 1, "R5 empty after ext load", tx_empty, 1);
            pulse_ack();
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule